// File: doc/BRIEF.md
# Programmable Odd/Even Clock Post-Divider

This block takes one of two high-rate source clocks, a PLL output or the raw reference, and divides it by a programmable integer. It then routes the divided clock to a clock output pin driver. The integer is the product of a 5-bit main divisor and a binary post factor of 1, 2, 4 or 8. The output stays at 50% duty for every total divisor. For an odd total, the high and low phases each last an exact number of half source cycles, because a rising-edge flop and a falling-edge flop are combined.

Configuration is static in normal use, but it may be changed while the divider runs. A new source, divisor or post code is adopted only when the current output period ends. Outputs that have no post stage are built with the post stage removed, and their post code is then ignored.

Top module: `clk_post_divider`

## Requirements
- R1: While `rst` is 1 or `en` is 0, `clk_out` is driven low from the first source clock edge onward and the counters stay cleared. After release, the first high phase starts at the first source edge.
- R2: For an even total divisor N, `clk_out` has a period of N source cycles and a high time of N/2 source cycles.
- R3: For an odd total divisor N of 3 or more, `clk_out` has a period of N source cycles and a high time of exactly N/2 source cycles, which is a whole number of half cycles.
- R4: A main divisor `p_div` of 1 passes the selected source clock straight to `clk_out`. A value of 0 is treated as 1.
- R5: `post_code` values 0, 1, 2 and 3 select post factors of 1, 2, 4 and 8, and the total divisor N is `p_div` times the factor.
- R6: `src_sel` = 0 selects `clk_pll` as the source and `src_sel` = 1 selects `clk_ref`.
- R7: A change to `src_sel`, `p_div` or `post_code` takes effect only after the output period in progress has completed with the old settings.
- R8: When the block is built with `HAS_POST` = 0, `post_code` is ignored and the post factor is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pll | input | 1 | PLL output clock, source 0 |
| clk_ref | input | 1 | Reference clock, source 1 |
| rst | input | 1 | Synchronous active-high reset, sampled by the selected source |
| en | input | 1 | Divider enable; 0 holds the counters cleared and the output low |
| src_sel | input | 1 | Source select: 0 = PLL, 1 = reference |
| p_div | input | P_W | Main divisor; 0 acts as 1 |
| post_code | input | POST_W | Post factor code: factor is 2 to the power of the code |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds two instances from the same stimulus.

The first instance uses the defaults (`P_W` = 5, `POST_W` = 2, `HAS_POST` = 1). With these it can reach total divisors from 1 up to 248. It covers pass-through, small and large even divisors, odd divisors that depend on the falling-edge flop, and both sources, whose periods are 20 ns and 30 ns.

The second instance uses `HAS_POST` = 0. It receives a nonzero post code while its period is measured, which shows that the code is ignored.

The period and high time are measured in the bench, in nanoseconds, from the output edges. They are compared against the source period times N and N/2.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
  typedef enum logic {SRC_PLL = 1'b0, SRC_REF = 1'b1} src_e;
endpackage

// File: rtl/pdiv_cfg.sv
`timescale 1ns/1ps
// Shadow of the divide settings, loaded only at a period boundary or while idle.
module pdiv_cfg
  import pdiv_pkg::*;
#(
  parameter int P_W      = 5,
  parameter int POST_W   = 2,
  parameter int HAS_POST = 1,
  parameter int N_W      = 8
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             load,
  input  src_e             src_i,
  input  logic [P_W-1:0]   p_i,
  input  logic [POST_W-1:0] post_i,
  output src_e             src_q,
  output logic [N_W-1:0]   n_q,
  output logic [N_W-1:0]   half_q,
  output logic             odd_q,
  output logic             byp_q
);
  logic [POST_W-1:0] code;
  logic [P_W-1:0]    p_eff;
  logic [N_W-1:0]    n_new;
  logic [N_W:0]      n_p1;

  generate
    if (HAS_POST != 0) begin : g_post
      assign code = post_i;
    end else begin : g_nopost
      assign code = '0;
    end
  endgenerate

  always_comb begin
    p_eff = (p_i == '0) ? P_W'(1) : p_i;
    n_new = N_W'(p_eff) << code;
    n_p1  = {1'b0, n_new} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hold || load) begin
      src_q  <= src_i;
      n_q    <= n_new;
      half_q <= n_p1[N_W:1];
      odd_q  <= n_new[0];
      byp_q  <= (n_new == N_W'(1));
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (hold)
    !load |=> $stable(n_q)); // R7
endmodule

// File: rtl/pdiv_count.sv
`timescale 1ns/1ps
// Period counter on the source rising edge; q_r is high for the first half_q counts.
module pdiv_count #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           hold,
  input  logic [N_W-1:0] n,
  input  logic [N_W-1:0] half,
  output logic           run,
  output logic           q_r,
  output logic           tc
);
  logic [N_W-1:0] cnt;

  assign tc = run && (cnt == n - 1'b1);

  always_ff @(posedge clk) begin
    if (hold) begin
      run <= 1'b0;
      cnt <= '0;
      q_r <= 1'b0;
    end else if (!run || tc) begin
      run <= 1'b1;
      cnt <= '0;
      q_r <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      q_r <= ((cnt + 1'b1) < half);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (hold)
    run |-> (cnt < n)); // R7
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (hold)
    $rose(q_r) |-> (cnt == '0)); // R2
endmodule

// File: rtl/pdiv_edge.sv
`timescale 1ns/1ps
// Falling-edge retime for odd divisors and output selection.
module pdiv_edge (
  input  logic clk,
  input  logic run,
  input  logic q_r,
  input  logic odd,
  input  logic byp,
  output logic out
);
  logic q_f;

  always_ff @(negedge clk) begin
    q_f <= q_r;
  end

  always_comb begin
    if (byp)      out = clk & run;
    else if (odd) out = q_r & q_f;
    else          out = q_r;
  end
endmodule

// File: rtl/clk_post_divider.sv
`timescale 1ns/1ps
module clk_post_divider
  import pdiv_pkg::*;
#(
  parameter int P_W      = 5,
  parameter int POST_W   = 2,
  parameter int HAS_POST = 1
) (
  input  logic              clk_pll,
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              en,
  input  logic              src_sel,
  input  logic [P_W-1:0]    p_div,
  input  logic [POST_W-1:0] post_code,
  output logic              clk_out
);
  localparam int N_W = P_W + (1 << POST_W) - 1;

  src_e           src_q;
  logic           src_clk;
  logic           hold;
  logic [N_W-1:0] n_q;
  logic [N_W-1:0] half_q;
  logic           odd_q;
  logic           byp_q;
  logic           run;
  logic           q_r;
  logic           tc;

  assign src_clk = (src_q == SRC_REF) ? clk_ref : clk_pll;
  assign hold    = rst | ~en;

  pdiv_cfg #(
    .P_W(P_W), .POST_W(POST_W), .HAS_POST(HAS_POST), .N_W(N_W)
  ) u_cfg (
    .clk(src_clk), .hold(hold), .load(tc | ~run),
    .src_i(src_e'(src_sel)), .p_i(p_div), .post_i(post_code),
    .src_q(src_q), .n_q(n_q), .half_q(half_q), .odd_q(odd_q), .byp_q(byp_q)
  );

  pdiv_count #(.N_W(N_W)) u_cnt (
    .clk(src_clk), .hold(hold), .n(n_q), .half(half_q),
    .run(run), .q_r(q_r), .tc(tc)
  );

  pdiv_edge u_edge (
    .clk(src_clk), .run(run), .q_r(q_r), .odd(odd_q), .byp(byp_q),
    .out(clk_out)
  );

  AST_IDLE_LOW: assert property (@(posedge src_clk) disable iff (rst)
    !run |-> !clk_out); // R1
endmodule

// File: tb/tb_clk_post_divider.sv
`timescale 1ns/1ps
module tb_clk_post_divider;
  logic       clk_pll = 1'b0;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       src_sel = 1'b0;
  logic [4:0] p_div = 5'd4;
  logic [1:0] post_code = 2'd0;
  logic       out_main, out_np, mon;
  bit         use_np = 1'b0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;

  always #10 clk_pll = ~clk_pll;   // 50 MHz, 20 ns
  always #15 clk_ref = ~clk_ref;   // 30 ns

  clk_post_divider dut (
    .clk_pll(clk_pll), .clk_ref(clk_ref), .rst(rst), .en(en),
    .src_sel(src_sel), .p_div(p_div), .post_code(post_code), .clk_out(out_main)
  );

  clk_post_divider #(.HAS_POST(0)) dut_np (
    .clk_pll(clk_pll), .clk_ref(clk_ref), .rst(rst), .en(en),
    .src_sel(src_sel), .p_div(p_div), .post_code(post_code), .clk_out(out_np)
  );

  assign mon = use_np ? out_np : out_main;

  task automatic chk(string tag, real act, real exp);
    n_chk++;
    if ((act - exp > 0.5) || (exp - act > 0.5)) begin
      n_bad++;
      $display("FAIL %s actual=%0.1f expected=%0.1f", tag, act, exp);
    end
  endtask

  task automatic setcfg(bit s, int p, int pc);
    @(negedge clk_pll); #1;
    src_sel = s; p_div = p[4:0]; post_code = pc[1:0];
  endtask

  task automatic measure(output real per, output real hi);
    realtime a, b, c;
    repeat (3) @(posedge mon);
    @(posedge mon); a = $realtime;
    @(negedge mon); b = $realtime;
    @(posedge mon); c = $realtime;
    per = c - a; hi = b - a;
  endtask

  task automatic run_case(string tag, bit s, int p, int pc, real tsrc, int n);
    real per, hi;
    setcfg(s, p, pc);
    measure(per, hi);
    chk({tag, " period"}, per, tsrc * n);
    chk({tag, " high"}, hi, tsrc * n / 2.0);
  endtask

  task automatic t_reset;
    repeat (4) @(posedge clk_pll);
    #3 chk("R1 output low in reset", real'(out_main), 0.0);
    @(negedge clk_pll); #1 rst = 1'b0;
  endtask

  task automatic t_even;
    run_case("R2 even P=4", 0, 4, 0, 20.0, 4);
    run_case("R2 even P=10", 0, 10, 0, 20.0, 10);
  endtask

  task automatic t_odd;
    run_case("R3 odd P=5", 0, 5, 0, 20.0, 5);
    run_case("R3 odd P=3", 0, 3, 0, 20.0, 3);
    run_case("R3 odd P=31", 0, 31, 0, 20.0, 31);
  endtask

  task automatic t_bypass;
    run_case("R4 P=1 passthrough", 0, 1, 0, 20.0, 1);
    run_case("R4 P=0 acts as 1", 0, 0, 0, 20.0, 1);
  endtask

  task automatic t_post;
    run_case("R5 P=3 code1 x2", 0, 3, 1, 20.0, 6);
    run_case("R5 P=3 code2 x4", 0, 3, 2, 20.0, 12);
    run_case("R5 P=31 code3 x8", 0, 31, 3, 20.0, 248);
    run_case("R5 P=1 code3 x8", 0, 1, 3, 20.0, 8);
  endtask

  task automatic t_src;
    run_case("R6 ref P=3", 1, 3, 0, 30.0, 3);
    run_case("R6 ref P=1", 1, 1, 0, 30.0, 1);
    run_case("R6 back to pll P=2", 0, 2, 0, 20.0, 2);
  endtask

  task automatic t_disable(int p);
    setcfg(0, p, 0);
    repeat (4) @(posedge out_main);
    @(negedge clk_pll); #1 en = 1'b0;
    repeat (2) @(posedge clk_pll);
    for (int i = 0; i < 8; i++) begin
      #7 chk("R1 output low when disabled", real'(out_main), 0.0);
    end
    @(negedge clk_pll); #1 en = 1'b1;
  endtask

  task automatic t_restart;
    realtime a, b, c;
    setcfg(0, 6, 0);
    @(negedge clk_pll); #1 en = 1'b0;
    repeat (3) @(posedge clk_pll);
    @(negedge clk_pll); #1 en = 1'b1;
    @(posedge out_main); a = $realtime;
    @(negedge out_main); b = $realtime;
    @(posedge out_main); c = $realtime;
    chk("R1 first period after enable", c - a, 120.0);
    chk("R1 first high after enable", b - a, 60.0);
  endtask

  task automatic t_update;
    realtime a, b, c;
    real per, hi;
    setcfg(0, 8, 0);
    repeat (3) @(posedge out_main);
    @(posedge out_main); a = $realtime;
    #5 p_div = 5'd2;
    @(negedge out_main); b = $realtime;
    @(posedge out_main); c = $realtime;
    chk("R7 old high kept", b - a, 80.0);
    chk("R7 old period kept", c - a, 160.0);
    @(posedge out_main); a = $realtime;
    chk("R7 new period after boundary", a - c, 40.0);
    measure(per, hi);
    chk("R7 new high", hi, 20.0);
  endtask

  task automatic t_nopost;
    use_np = 1'b1;
    run_case("R8 no post stage code3 ignored", 0, 3, 3, 20.0, 3);
    run_case("R8 no post stage code1 ignored", 0, 4, 1, 20.0, 4);
    use_np = 1'b0;
  endtask

  always @(posedge clk_pll) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_bypass();
    t_post();
    t_src();
    t_disable(1);
    t_disable(5);
    t_restart();
    t_update();
    t_nopost();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule